// File: doc/BRIEF.md
# Configuration Power-Up Sequencer

This block starts the configuration of a programmable logic device that loads its bitstream from a serial flash. The flash shares pins with an SDRAM. After a power-on reset or a reset request, the sequencer first releases the flash-disable line to high impedance. The target can then drive the flash chip select on its own. Next, the sequencer drives the target's active-low program pin low for a fixed pulse and then waits for the configuration-done line to rise.

When done is seen in time, a mode flag decides who owns the shared pins:
- With the flag clear, the flash-disable line is driven high. This switches the flash off and leaves the pins to the SDRAM.
- With the flag set, the line stays released, so user logic can reach the flash.

If done does not rise within a programmable number of cycles, the sequencer parks in a failure state. There it holds the program pin low, which keeps the target cleared, and raises a fail status until the next reset.

The states are IDLE, PULSE, WAIT_DONE, RUN_SDRAM, RUN_FLASH and FAIL. The transitions are:
- IDLE→PULSE: one cycle after reset ends.
- PULSE→WAIT_DONE: after the pulse length.
- WAIT_DONE→RUN_SDRAM: on a detected done rise with the flag clear.
- WAIT_DONE→RUN_FLASH: on a detected done rise with the flag set.
- WAIT_DONE→FAIL: on timeout.
- Any state→IDLE: while the reset request is high.

Top module: `cfg_powerup_seq`

## Requirements
- R1: While `rst_n` is low, and in the cycle after any clock edge that saw `reset_req` high, the block is in IDLE: `prog_n`=1, `fdis_oe`=0, `fdis_level`=0, `cfg_busy`=1, `cfg_fail`=0, `flash_mode`=0.
- R2: IDLE lasts exactly one cycle once `reset_req` is low, then PULSE follows. While `reset_req` stays high, the block remains in IDLE.
- R3: In PULSE, `prog_n` is 0 for exactly `PULSE_LEN` cycles (default 16) and `fdis_oe` is 0. Afterwards `prog_n` returns to 1 in WAIT_DONE.
- R4: `done_i` passes through a two-flop synchronizer. Only a low-to-high change counts as completion, and the sampling register starts at 1 after reset. The state leaves WAIT_DONE on the third rising clock edge after the first edge that samples `done_i` high following a low sample.
- R5: Completion with `flash_keep`=0 enters RUN_SDRAM: `fdis_oe`=1, `fdis_level`=1, `cfg_busy`=0, `prog_n`=1.
- R6: Completion with `flash_keep`=1 enters RUN_FLASH: `fdis_oe`=0, `flash_mode`=1, `cfg_busy`=0. The flag is sampled only at the completion edge; later changes of `flash_keep` leave the outputs unchanged.
- R7: If no completion occurs within `timeout_cycles` cycles of WAIT_DONE, the block enters FAIL: `prog_n`=0, `cfg_fail`=1, `cfg_busy`=0, `fdis_oe`=0. FAIL is held until a reset. A `timeout_cycles` of 0 acts as 1.
- R8: A `done_i` that is high throughout, with no low sample, never counts as completion, and the block ends in FAIL.
- R9: In RUN_SDRAM and RUN_FLASH, changes of `done_i` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| reset_req | input | 1 | Synchronous request to restart configuration |
| done_i | input | 1 | Configuration-done line from target (pulled up) |
| flash_keep | input | 1 | 1 = leave flash enabled after configuration |
| timeout_cycles | input | TMO_W | Cycles allowed in WAIT_DONE |
| prog_n | output | 1 | Active-low program pin of the target |
| fdis_oe | output | 1 | Drive enable for the flash-disable line (0 = high impedance) |
| fdis_level | output | 1 | Level for the flash-disable line when driven |
| cfg_busy | output | 1 | Sequence in progress (IDLE, PULSE, WAIT_DONE) |
| cfg_fail | output | 1 | Configuration failed |
| flash_mode | output | 1 | Configured with flash left accessible |

## Verification
Every output is a pure decode of the state, so a wrong state shows at the ports in the same cycle. Some examples:
- A pulse that is one cycle short or long shows as a `prog_n` edge in the wrong cycle.
- A misread flag shows as a flipped `fdis_oe` at the first running cycle.
- A lost timeout shows as `cfg_busy` staying high past the limit.

The bench runs a cycle-level reference model and compares all six outputs on every clock, so any divergence is reported within one cycle of its cause.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_PULSE     = 3'd1,
        ST_WAIT_DONE = 3'd2,
        ST_RUN_SDRAM = 3'd3,
        ST_RUN_FLASH = 3'd4,
        ST_FAIL      = 3'd5
    } seq_state_t;
endpackage

// File: rtl/cfg_done_sync.sv
module cfg_done_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic done_async,
    output logic done_rise
);
    // Idle level of a pulled-up line is high, so start all stages at 1.
    logic s1_q, s2_q, s3_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 1'b1;
            s2_q <= 1'b1;
            s3_q <= 1'b1;
        end else begin
            s1_q <= done_async;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign done_rise = s2_q & ~s3_q;
endmodule

// File: rtl/cfg_seq_timer.sv
module cfg_seq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    output logic [W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (count != {W{1'b1}}) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/cfg_powerup_seq.sv
module cfg_powerup_seq
    import cfg_seq_pkg::*;
#(
    parameter int PULSE_LEN = 16,
    parameter int TMO_W     = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reset_req,
    input  logic             done_i,
    input  logic             flash_keep,
    input  logic [TMO_W-1:0] timeout_cycles,
    output logic             prog_n,
    output logic             fdis_oe,
    output logic             fdis_level,
    output logic             cfg_busy,
    output logic             cfg_fail,
    output logic             flash_mode
);
    localparam int PW    = $clog2(PULSE_LEN + 1);
    localparam int CNT_W = ((TMO_W > PW) ? TMO_W : PW) + 1;
    localparam int CMP_W = CNT_W + 1;
    localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(PULSE_LEN - 1);

    seq_state_t       state_q, state_d;
    logic             rise;
    logic [CNT_W-1:0] cnt;
    logic             tmo_hit;

    cfg_done_sync u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .done_async (done_i),
        .done_rise  (rise)
    );

    cfg_seq_timer #(.W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state_d != state_q),
        .count (cnt)
    );

    assign tmo_hit = ({1'b0, cnt} + CMP_W'(1)) >= CMP_W'(timeout_cycles);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (reset_req) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_PULSE;
                ST_PULSE:     if (cnt == PULSE_LAST) state_d = ST_WAIT_DONE;
                ST_WAIT_DONE: begin
                    if (rise)         state_d = flash_keep ? ST_RUN_FLASH : ST_RUN_SDRAM;
                    else if (tmo_hit) state_d = ST_FAIL;
                end
                ST_RUN_SDRAM: state_d = ST_RUN_SDRAM;
                ST_RUN_FLASH: state_d = ST_RUN_FLASH;
                ST_FAIL:      state_d = ST_FAIL;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output decode
    always_comb begin
        prog_n     = 1'b1;
        fdis_oe    = 1'b0;
        fdis_level = 1'b0;
        cfg_busy   = 1'b0;
        cfg_fail   = 1'b0;
        flash_mode = 1'b0;
        unique case (state_q)
            ST_IDLE:      cfg_busy = 1'b1;
            ST_PULSE:     begin cfg_busy = 1'b1; prog_n = 1'b0; end
            ST_WAIT_DONE: cfg_busy = 1'b1;
            ST_RUN_SDRAM: begin fdis_oe = 1'b1; fdis_level = 1'b1; end
            ST_RUN_FLASH: flash_mode = 1'b1;
            ST_FAIL:      begin prog_n = 1'b0; cfg_fail = 1'b1; end
            default:      cfg_busy = 1'b1;
        endcase
    end

    // Assertions
    p_idle_to_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !reset_req) |=> (state_q == ST_PULSE));

    p_pulse_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PULSE) |-> (cnt <= PULSE_LAST));

    p_rise_exits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_DONE && rise && !reset_req)
        |=> (state_q == ST_RUN_SDRAM || state_q == ST_RUN_FLASH));

    p_sdram_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN_SDRAM) |-> (fdis_oe && fdis_level && prog_n));

    p_flash_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN_FLASH && !reset_req) |=> (!fdis_oe && flash_mode));

    p_fail_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_fail && !reset_req) |=> (cfg_fail && !prog_n));

    p_run_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN_SDRAM && !reset_req) |=> $stable(fdis_oe));
endmodule

// File: tb/test_cfg_powerup_seq.sv
module test_cfg_powerup_seq;
    localparam int CLK_P = 10;
    localparam int PL    = 16;
    localparam int TW    = 21;

    logic clk = 0, rst_n = 0, reset_req = 0, done_i = 1, flash_keep = 0;
    logic [TW-1:0] timeout_cycles = 40;
    logic prog_n, fdis_oe, fdis_level, cfg_busy, cfg_fail, flash_mode;

    int errors = 0, checks = 0, cycles = 0;

    cfg_powerup_seq #(.PULSE_LEN(PL), .TMO_W(TW)) i_cfg_powerup_seq (
        .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .done_i(done_i),
        .flash_keep(flash_keep), .timeout_cycles(timeout_cycles),
        .prog_n(prog_n), .fdis_oe(fdis_oe), .fdis_level(fdis_level),
        .cfg_busy(cfg_busy), .cfg_fail(cfg_fail), .flash_mode(flash_mode)
    );

    always #(CLK_P/2) clk = ~clk;

    // Reference model: 0 idle, 1 pulse, 2 wait, 3 sdram, 4 flash, 5 fail
    int m_st = 0;
    int m_cnt = 0;
    bit hist[$] = '{1, 1, 1};

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; hist = '{1, 1, 1};
        end else begin
            int nx;
            bit rz;
            rz = hist[1] && !hist[2];
            nx = m_st;
            if (reset_req) nx = 0;
            else case (m_st)
                0: nx = 1;
                1: if (m_cnt == PL - 1) nx = 2;
                2: if (rz) nx = flash_keep ? 4 : 3;
                   else if (m_cnt + 1 >= int'(timeout_cycles)) nx = 5;
                default: nx = m_st;
            endcase
            m_cnt = (nx != m_st) ? 0 : m_cnt + 1;
            m_st = nx;
            hist.push_front(done_i);
            hist = hist[0:2];
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        bit e_prog, e_oe, e_busy, e_fail, e_fm;
        e_prog = !(m_st == 1 || m_st == 5);
        e_oe   = (m_st == 3);
        e_busy = (m_st <= 2);
        e_fail = (m_st == 5);
        e_fm   = (m_st == 4);
        chk(prog_n == e_prog, "R3 prog_n", prog_n, e_prog);
        chk(fdis_oe == e_oe && fdis_level == e_oe, "R5 fdis", {fdis_oe, fdis_level}, {e_oe, e_oe});
        chk(cfg_busy == e_busy, "R2 busy", cfg_busy, e_busy);
        chk(cfg_fail == e_fail, "R7 fail", cfg_fail, e_fail);
        chk(flash_mode == e_fm, "R6 flash_mode", flash_mode, e_fm);
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 20000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic restart();
        reset_req = 1; step(1); reset_req = 0;
    endtask

    initial begin
        step(2);
        #(CLK_P/2);
        // R1: outputs during power-on reset
        chk(prog_n && !fdis_oe && cfg_busy && !cfg_fail && !flash_mode, "R1 reset state", prog_n, 1);
        rst_n = 1;
        step(1);
        // R3: pulse active, done driven low by target during pulse
        chk(!prog_n, "R3 pulse low", prog_n, 0);
        done_i = 0; step(PL + 3);
        chk(prog_n && cfg_busy, "R3 pulse ended", prog_n, 1);
        done_i = 1; step(2);
        chk(cfg_busy, "R4 still waiting two edges later", cfg_busy, 1);
        step(1);
        // R5: SDRAM ownership
        chk(fdis_oe && fdis_level && !cfg_busy, "R5 sdram drive", fdis_oe, 1);
        // R9: done toggles ignored
        done_i = 0; step(5); done_i = 1; step(5);
        chk(fdis_oe && !cfg_busy, "R9 done ignored", fdis_oe, 1);

        // R6: flash kept, flag changes later ignored
        restart(); flash_keep = 1; done_i = 0; step(PL + 5); done_i = 1; step(4);
        chk(flash_mode && !fdis_oe, "R6 flash mode", flash_mode, 1);
        flash_keep = 0; step(6);
        chk(flash_mode && !fdis_oe, "R6 flag change ignored", flash_mode, 1);

        // R7: timeout with done held low
        restart(); done_i = 0; timeout_cycles = 30; step(PL + 40);
        chk(cfg_fail && !prog_n, "R7 timeout fail", cfg_fail, 1);
        done_i = 1; step(8);
        chk(cfg_fail && !prog_n, "R7 fail sticky", cfg_fail, 1);

        // R8: done stuck high
        restart(); timeout_cycles = 25; step(PL + 30);
        chk(cfg_fail, "R8 stuck high fails", cfg_fail, 1);

        // R7: timeout zero acts as one
        restart(); timeout_cycles = 0; step(PL + 1);
        chk(cfg_busy, "R7 zero timeout wait", cfg_busy, 1);
        step(1);
        chk(cfg_fail, "R7 zero timeout fail", cfg_fail, 1);

        // R2: held reset request keeps idle
        timeout_cycles = 40; reset_req = 1; step(6);
        chk(cfg_busy && prog_n, "R2 held idle", prog_n, 1);
        reset_req = 0; step(1);
        chk(!prog_n, "R2 pulse after idle", prog_n, 0);

        // R4: rise near end of window, restart mid-wait
        done_i = 0; step(PL + 2); restart(); step(PL + 3);
        done_i = 1; step(3);
        chk(fdis_oe && !cfg_busy, "R4 completion after restart", fdis_oe, 1);

        // R1: async reset mid-run
        #1; rst_n = 0; #1;
        chk(cfg_busy && !fdis_oe && prog_n, "R1 async reset", cfg_busy, 1);
        step(2); rst_n = 1; step(3);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule